// File: doc/BRIEF.md
# Two-Channel DAC Serial Write Front End

This block is the serial control side of a two-channel digital-to-analog converter. It listens on an I2C bus as a write-only slave. Each transfer is four bytes long: the slave address with the write bit, a command/channel byte, and a 16-bit code sent most significant byte first. The block acknowledges each byte of a transfer addressed to it. It keeps, for every channel, an input register and a DAC register that feeds the converter. Decoded commands load the input register, copy it into the DAC register, do both at once, or put the channel to sleep.

A separate active-low load strobe works beside the bus. A falling edge of the strobe that follows a complete write-input transfer commits the input register of the channels that transfer named. A low strobe with no such transfer pending only wakes sleeping channels. While the strobe is low, power-down commands have no effect. The bus lines and the strobe are sampled by the system clock through two-flop synchronizers, so the system clock must run well above the bus bit rate. The low three address bits come in as ready-made digital levels.

Top module: `dac_i2c_front`

## Requirements
- R1: After reset every DAC code output is 0, every sleep flag is 0 and `sda_pull` is 0.
- R2: The block answers address {4'b0010, chip_addr[2:0]} when the first byte is {address[6:0], 1'b0}. It raises `sda_pull` during the ninth clock of each of the four bytes.
- R3: A first byte with another address, or with bit 0 (read) set, is not acknowledged, and `sda_pull` stays 0 for the rest of the transfer. No register changes.
- R4: The second byte is {cmd[3:0], chan[3:0]}. Command 4'b0000 loads the 16-bit code (third byte high, fourth byte low) into the input register and leaves the DAC code unchanged. Channel 4'b0000 is channel 0, 4'b0001 is channel 1 and 4'b1111 is both. Any other channel value changes nothing.
- R5: Command 4'b0001 copies the input register of the selected channels into their DAC code.
- R6: Command 4'b0011 loads the code into both the input register and the DAC code of the selected channels.
- R7: Command 4'b0100 sets the sleep flag of the selected channels. Command codes other than 0000, 0001, 0011 and 0100 change nothing.
- R8: Commands 0000, 0001 and 0011 clear the sleep flag of every channel they select.
- R9: A START or STOP before the fourth acknowledge is complete ends the transfer, and no register changes.
- R10: A falling edge of `load_n` after a complete command-0000 transfer copies the input register into the DAC code of the channels that transfer selected. It does this once per such transfer. Any other complete transfer cancels a pending commit.
- R11: While `load_n` is low, all sleep flags are cleared. Without a pending commit, the DAC codes do not change.
- R12: A power-down command received while `load_n` is low leaves the sleep flags at 0.
- R13: With `load_n` held high, DAC codes change only through commands 0001 and 0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | High to pull the data line low (open-drain acknowledge) |
| chip_addr | input | 3 | Low three bits of the slave address |
| load_n | input | 1 | Asynchronous active-low load strobe |
| dac_code | output | NCH*CODE_W (32) | DAC register codes, channel 0 in the low half |
| sleep | output | NCH (2) | Per-channel power-down flags, bit 0 for channel 0 |

## Verification
The command decoder is driven with each of the four valid codes, one unused code, and each channel select: single, both, and an unused value. Together these separate an input-register load from a DAC-register load and show that selection reaches only the named channels. Transfers with a wrong address, with the read bit set, or broken by a START or STOP part way through show that only complete addressed transfers change state. The load strobe is pulsed after a write-input transfer, pulsed with no commit pending, and held low across a power-down transfer. These cases tell a commit apart from a wake-only event and from a blocked power-down.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam logic [3:0] CMD_WR_IN  = 4'b0000;
  localparam logic [3:0] CMD_UPD    = 4'b0001;
  localparam logic [3:0] CMD_WR_UPD = 4'b0011;
  localparam logic [3:0] CMD_PWRDN  = 4'b0100;
  localparam logic [3:0] SEL_ALL    = 4'b1111;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_ACK,
    RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [3:0]  chan;
    logic [15:0] data;
  } dac_frame_t;

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe, sda_pipe;
  logic         scl_d, sda_d;
  logic         scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_in};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_in};
      scl_d    <= scl_pipe[MSB];
      sda_d    <= sda_pipe[MSB];
    end
  end

  assign scl_q     = scl_pipe[MSB];
  assign sda_q     = sda_pipe[MSB];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import dacif_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [2:0] chip_addr,
  output logic       sda_pull,
  output logic       frame_vld,
  output dac_frame_t frame_q
);

  localparam int BYTES   = 4;
  localparam int BYTE_W  = $clog2(BYTES);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BYTES - 1);

  rx_state_e         state_q, state_n;
  logic [3:0]        bit_cnt_q, bit_cnt_n;
  logic [BYTE_W-1:0] byte_cnt_q, byte_cnt_n;
  logic [7:0]        shreg_q, shreg_n;
  logic [7:0]        cmd_byte_q, cmd_byte_n;
  logic [7:0]        hi_byte_q, hi_byte_n;
  dac_frame_t        frame_n;
  logic              vld_n;
  logic              addr_ok;

  assign addr_ok = (shreg_q == {ADDR_HI, chip_addr, 1'b0});

  always_comb begin
    state_n    = state_q;
    bit_cnt_n  = bit_cnt_q;
    byte_cnt_n = byte_cnt_q;
    shreg_n    = shreg_q;
    cmd_byte_n = cmd_byte_q;
    hi_byte_n  = hi_byte_q;
    frame_n    = frame_q;
    vld_n      = 1'b0;
    if (start_det) begin
      state_n    = RX_SHIFT;
      bit_cnt_n  = '0;
      byte_cnt_n = '0;
    end else if (stop_det) begin
      state_n = RX_IDLE;
    end else begin
      case (state_q)
        RX_SHIFT: begin
          if (scl_rise && bit_cnt_q < BITS_PER_BYTE) begin
            shreg_n   = {shreg_q[6:0], sda_q};
            bit_cnt_n = bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == BITS_PER_BYTE) begin
            bit_cnt_n = '0;
            state_n   = RX_ACK;
            case (byte_cnt_q)
              2'd0: if (!addr_ok) state_n = RX_IDLE;
              2'd1: cmd_byte_n = shreg_q;
              2'd2: hi_byte_n  = shreg_q;
              default: frame_n = {cmd_byte_q, hi_byte_q, shreg_q};
            endcase
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            if (byte_cnt_q == LAST_BYTE) begin
              state_n = RX_HOLD;
              vld_n   = 1'b1;
            end else begin
              byte_cnt_n = byte_cnt_q + 1'b1;
              state_n    = RX_SHIFT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      shreg_q    <= '0;
      cmd_byte_q <= '0;
      hi_byte_q  <= '0;
      frame_q    <= '0;
      frame_vld  <= 1'b0;
    end else begin
      state_q    <= state_n;
      bit_cnt_q  <= bit_cnt_n;
      byte_cnt_q <= byte_cnt_n;
      shreg_q    <= shreg_n;
      cmd_byte_q <= cmd_byte_n;
      hi_byte_q  <= hi_byte_n;
      frame_q    <= frame_n;
      frame_vld  <= vld_n;
    end
  end

  assign sda_pull = (state_q == RX_ACK);

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == RX_SHIFT && bit_cnt_q == 4'd0 && !frame_vld));

  // R2
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  // R2
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> ($past(scl_fall) && $past(bit_cnt_q) == BITS_PER_BYTE));

endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dacif_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  logic [3:0]        cmd,
  input  logic [CODE_W-1:0] data,
  input  logic              commit,
  input  logic              wake_all,
  output logic [CODE_W-1:0] dac_q,
  output logic              sleep_q
);

  logic [CODE_W-1:0] in_q, in_n, dac_n;
  logic              sleep_n;
  logic              in_en, dac_en, sleep_en;

  always_comb begin
    in_n     = in_q;
    dac_n    = dac_q;
    sleep_n  = sleep_q;
    in_en    = 1'b0;
    dac_en   = 1'b0;
    sleep_en = 1'b0;
    if (commit) begin
      dac_n  = in_q;
      dac_en = 1'b1;
    end
    if (cmd_hit) begin
      case (cmd)
        CMD_WR_IN: begin
          in_n = data; in_en = 1'b1;
          sleep_n = 1'b0; sleep_en = 1'b1;
        end
        CMD_UPD: begin
          dac_n = in_q; dac_en = 1'b1;
          sleep_n = 1'b0; sleep_en = 1'b1;
        end
        CMD_WR_UPD: begin
          in_n = data; in_en = 1'b1;
          dac_n = data; dac_en = 1'b1;
          sleep_n = 1'b0; sleep_en = 1'b1;
        end
        CMD_PWRDN: begin
          sleep_n = 1'b1; sleep_en = 1'b1;
        end
        default: ;
      endcase
    end
    if (wake_all) begin
      sleep_n  = 1'b0;
      sleep_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      dac_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      if (in_en)    in_q    <= in_n;
      if (dac_en)   dac_q   <= dac_n;
      if (sleep_en) sleep_q <= sleep_n;
    end
  end

  // R12
  sleep_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> !$past(wake_all));

  // R11
  wake_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_all && !commit && !cmd_hit) |=> $stable(dac_q));

endmodule

// File: rtl/dac_i2c_front.sv
module dac_i2c_front
  import dacif_pkg::*;
#(
  parameter int         CODE_W      = 16,
  parameter int         NCH         = 2,
  parameter logic [3:0] ADDR_HI     = 4'b0010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_pull,
  input  logic [2:0]                 chip_addr,
  input  logic                       load_n,
  output logic [NCH-1:0][CODE_W-1:0] dac_code,
  output logic [NCH-1:0]             sleep
);

  localparam int LMSB = SYNC_STAGES - 1;

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [LMSB:0] ld_pipe;
  logic          ld_d, ld_fall, ld_low;
  logic          sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic          frame_vld;
  dac_frame_t    frm;
  logic [NCH-1:0] sel, commit;
  logic           armed_q, armed_n;
  logic [NCH-1:0] armed_sel_q, armed_sel_n;
  logic           frame_arms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ld_pipe <= '1;
      ld_d    <= 1'b1;
    end else begin
      ld_pipe <= {ld_pipe[LMSB-1:0], load_n};
      ld_d    <= ld_pipe[LMSB];
    end
  end
  assign ld_low  = ~ld_pipe[LMSB];
  assign ld_fall = ld_d & ~ld_pipe[LMSB];

  bus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  frame_rx #(.ADDR_HI(ADDR_HI)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .chip_addr(chip_addr), .sda_pull(sda_pull), .frame_vld(frame_vld),
    .frame_q(frm)
  );

  assign frame_arms = frame_vld && (frm.cmd == CMD_WR_IN) && (|sel);

  always_comb begin
    armed_n     = armed_q;
    armed_sel_n = armed_sel_q;
    if (frame_vld) begin
      armed_n     = frame_arms;
      armed_sel_n = sel;
    end else if (ld_fall) begin
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed_q     <= 1'b0;
      armed_sel_q <= '0;
    end else begin
      armed_q     <= armed_n;
      armed_sel_q <= armed_sel_n;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign sel[i]    = (frm.chan == 4'(i)) || (frm.chan == SEL_ALL);
    assign commit[i] = ld_fall & armed_q & armed_sel_q[i];

    dac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .cmd_hit(frame_vld & sel[i]), .cmd(frm.cmd),
      .data(frm.data[15 -: CODE_W]), .commit(commit[i]),
      .wake_all(ld_low), .dac_q(dac_code[i]), .sleep_q(sleep[i])
    );
  end

  // R10
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_fall && !frame_vld) |=> !armed_q);

endmodule

// File: tb/tb_dac_i2c_front.sv
module tb_dac_i2c_front;

  localparam int Q = 4;
  localparam logic [6:0] MY_ADDR = 7'h15;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic sda_pull;
  logic [2:0] chip_addr;
  logic load_n;
  logic [1:0][15:0] dcode;
  logic [1:0] sleep;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  dac_i2c_front dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .chip_addr(chip_addr), .load_n(load_n),
    .dac_code(dcode), .sleep(sleep)
  );

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wcyc(Q);
    m_scl = 1'b1; wcyc(Q);
    m_sda = 1'b0; wcyc(2*Q);
    m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wcyc(Q);
    m_scl = 1'b1; wcyc(2*Q);
    m_sda = 1'b1; wcyc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wcyc(Q);
      m_scl = 1'b1; wcyc(2*Q);
      m_scl = 1'b0; wcyc(Q);
    end
    m_sda = 1'b1; wcyc(Q);
    m_scl = 1'b1; wcyc(Q);
    acked = sda_pull;
    wcyc(Q);
    m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw, input logic [3:0] c,
                      input logic [3:0] ch, input logic [15:0] d, output logic [3:0] ak);
    bus_start;
    send_byte({a, rw}, ak[3]);
    send_byte({c, ch}, ak[2]);
    send_byte(d[15:8], ak[1]);
    send_byte(d[7:0], ak[0]);
    bus_stop;
    wcyc(10);
  endtask

  task automatic pulse_load;
    load_n = 1'b0; wcyc(8);
    load_n = 1'b1; wcyc(8);
  endtask

  task automatic t_reset;
    chk("R1 dac0", dcode[0], 0);
    chk("R1 dac1", dcode[1], 0);
    chk("R1 sleep", sleep, 0);
    chk("R1 sda_pull", sda_pull, 0);
  endtask

  task automatic t_write_then_update;
    logic [3:0] ak;
    xfer(MY_ADDR, 1'b0, 4'b0000, 4'b0000, 16'h1234, ak);
    chk("R2 acks", ak, 4'b1111);
    chk("R4 R13 dac0 held", dcode[0], 0);
    xfer(MY_ADDR, 1'b0, 4'b0001, 4'b0000, 16'h0000, ak);
    chk("R5 dac0 updated", dcode[0], 16'h1234);
    chk("R5 dac1 untouched", dcode[1], 0);
  endtask

  task automatic t_write_update_both;
    logic [3:0] ak;
    xfer(MY_ADDR, 1'b0, 4'b0011, 4'b1111, 16'hBEEF, ak);
    chk("R6 dac0", dcode[0], 16'hBEEF);
    chk("R6 dac1", dcode[1], 16'hBEEF);
  endtask

  task automatic t_ignored_codes;
    logic [3:0] ak;
    xfer(MY_ADDR, 1'b0, 4'b0011, 4'b0101, 16'h1111, ak);
    chk("R4 bad chan", dcode, {16'hBEEF, 16'hBEEF});
    xfer(MY_ADDR, 1'b0, 4'b0111, 4'b1111, 16'h2222, ak);
    chk("R7 bad cmd dac", dcode, {16'hBEEF, 16'hBEEF});
    chk("R7 bad cmd sleep", sleep, 0);
  endtask

  task automatic t_power;
    logic [3:0] ak;
    xfer(MY_ADDR, 1'b0, 4'b0100, 4'b0000, 16'h0, ak);
    chk("R7 sleep ch0", sleep, 2'b01);
    xfer(MY_ADDR, 1'b0, 4'b0100, 4'b1111, 16'h0, ak);
    chk("R7 sleep all", sleep, 2'b11);
    xfer(MY_ADDR, 1'b0, 4'b0000, 4'b0001, 16'h2222, ak);
    chk("R8 write wakes ch1", sleep, 2'b01);
    chk("R4 dac1 held", dcode[1], 16'hBEEF);
    xfer(MY_ADDR, 1'b0, 4'b0001, 4'b0000, 16'h0, ak);
    chk("R8 update wakes ch0", sleep, 2'b00);
  endtask

  task automatic t_nack;
    logic [3:0] ak;
    xfer(7'h14, 1'b0, 4'b0011, 4'b0000, 16'h5555, ak);
    chk("R3 wrong addr acks", ak, 4'b0000);
    chk("R3 wrong addr dac", dcode[0], 16'hBEEF);
    xfer(MY_ADDR, 1'b1, 4'b0011, 4'b0000, 16'h5555, ak);
    chk("R3 read bit acks", ak, 4'b0000);
    chk("R3 read bit dac", dcode[0], 16'hBEEF);
  endtask

  task automatic t_abort;
    logic a;
    bus_start;
    send_byte({MY_ADDR, 1'b0}, a);
    send_byte({4'b0011, 4'b1111}, a);
    bus_stop;
    wcyc(10);
    chk("R9 stop abort", dcode, {16'hBEEF, 16'hBEEF});
    bus_start;
    send_byte({MY_ADDR, 1'b0}, a);
    send_byte({4'b0011, 4'b1111}, a);
    send_byte(8'h77, a);
    bus_start;
    bus_stop;
    wcyc(10);
    chk("R9 start abort", dcode, {16'hBEEF, 16'hBEEF});
  endtask

  task automatic t_load_commit;
    logic [3:0] ak;
    xfer(MY_ADDR, 1'b0, 4'b0000, 4'b0001, 16'h3333, ak);
    chk("R13 before load", dcode[1], 16'hBEEF);
    pulse_load;
    chk("R10 commit ch1", dcode[1], 16'h3333);
    chk("R10 ch0 untouched", dcode[0], 16'hBEEF);
  endtask

  task automatic t_load_wake;
    logic [3:0] ak;
    xfer(MY_ADDR, 1'b0, 4'b0100, 4'b1111, 16'h0, ak);
    chk("R7 sleep before wake", sleep, 2'b11);
    pulse_load;
    chk("R11 woken", sleep, 2'b00);
    chk("R11 codes held", dcode, {16'h3333, 16'hBEEF});
  endtask

  task automatic t_load_blocks_pd;
    logic [3:0] ak;
    load_n = 1'b0; wcyc(8);
    xfer(MY_ADDR, 1'b0, 4'b0100, 4'b1111, 16'h0, ak);
    chk("R12 pd blocked", sleep, 2'b00);
    load_n = 1'b1; wcyc(8);
    chk("R12 after release", sleep, 2'b00);
    xfer(MY_ADDR, 1'b0, 4'b0100, 4'b0000, 16'h0, ak);
    chk("R12 pd with load high", sleep, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; load_n = 1'b1;
    chip_addr = MY_ADDR[2:0];
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    t_reset;
    t_write_then_update;
    t_write_update_both;
    t_ignored_codes;
    t_power;
    t_nack;
    t_abort;
    t_load_commit;
    t_load_wake;
    t_load_blocks_pd;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule